// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This block decides whether the rest of the system has power. It runs on a 32768 Hz slow clock and holds one output, `pwr_en`, that is high while the system runs. Software turns power off by writing a shutdown command that carries a key byte, so a stray store cannot cut power. While the system is off, the block watches up to sixteen wake-up pins and a real-time-clock alarm line. When one of them fires, power comes back on.

Each pin has its own enable and its own active level. A pin event counts only after the pin has stayed at its active level for a debounce length that software chooses from a fixed table of slow-clock counts. Any break in that level restarts the count. The alarm line has no debounce. On a wake, the cause is latched in a status word. Reading that word clears it, so each cause is reported once. All-zero status means a plain power-on.

Access goes through four 32-bit word registers on a simple read/write strobe bus. Reads are combinational. Writes and read side effects take place at the clock edge that samples the strobe.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1 and every register reads back as zero.
- R2: A write to word offset 0x00 with bit 0 set and bits 31:24 equal to 0xA5 drives `pwr_en` low from the cycle after the write edge.
- R3: A write to offset 0x00 with any other key byte, or with bit 0 clear, leaves `pwr_en` unchanged.
- R4: In the pin configuration word at offset 0x0C, bit n enables pin n and bit 16+n sets its active level (1 = high, 0 = low). A disabled pin, or a pin held at its inactive level, never wakes the system.
- R5: In the mode word at offset 0x04, bits 26:24 select the debounce length L: 0→0, 1→3, 2→32, 3→512, 4→4096, 5, 6 and 7→32768. A pin first seen active at edge k wakes the system at edge k+L if it stays active at every edge in between. `pwr_en` is high from the next cycle.
- R6: A pin that leaves its active level before the count completes restarts its count from zero.
- R7: Mode bit 17 enables the alarm input. While off with the alarm enabled, an alarm high at any edge wakes the system at that edge with no debounce and sets status bit 5. With bit 17 clear, the alarm has no effect.
- R8: The status word at offset 0x08 has bit 16+n set for pin n and bit 5 set for the alarm. Every cause that fires at the same wake edge is recorded.
- R9: A read of the status word returns its value and clears it at that edge.
- R10: Pin or alarm activity while `pwr_en` is high sets no status bit and does not change power.
- R11: The mode word reads back only bits 26:24 and bit 17, with all other bits zero. The configuration word reads back all 32 bits as written.
- R12: With mode and configuration both zero, no pin or alarm activity ends a shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe. Its only side effect is clearing the status word |
| bus_addr | input | 4 | Byte address. Only word-aligned addresses are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wake_pin | input | 16 | Wake-up pins, synchronous to `clk` |
| rtc_alarm | input | 1 | Real-time-clock alarm level |
| pwr_en | output | 1 | System power enable, high while running |

## Verification
The timing rules are as follows:
- A shutdown write shows on `pwr_en` one cycle after its edge.
- A pin first seen active at edge k shows `pwr_en` high after edge k+L. The bench holds the pin and checks that power is still off at the L-th falling edge and back on at the next one.
- An alarm wake shows on `pwr_en` one cycle after the alarm edge.
- Read data is combinational, so it is sampled within the read cycle, before the edge that clears the status.

A behavioural model in the bench advances on the same edges. The bench compares `pwr_en` and any read data against that model a fixed delay after every falling clock edge. Direct checks, tied to the cycle counts above, cover the debounce table, glitch restart and simultaneous causes.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int unsigned SWC_DW        = 32;
    localparam int unsigned SWC_MAX_PINS  = 16;
    localparam int unsigned SWC_CNT_W     = 16;
    localparam int unsigned SWC_SEL_W     = 3;

    // bit positions that software depends on
    localparam int unsigned SEL_LSB       = 24;
    localparam int unsigned RTC_EN_BIT    = 17;
    localparam int unsigned RTC_STAT_BIT  = 5;
    localparam int unsigned PIN_STAT_LSB  = 16;
    localparam int unsigned POL_LSB       = 16;
    localparam int unsigned KEY_LSB       = 24;
    localparam logic [7:0]  SHUT_KEY      = 8'hA5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_WCFG = 2'd3
    } swc_reg_e;

    typedef enum logic {
        PWR_ON  = 1'b0,
        PWR_OFF = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic [SWC_SEL_W-1:0] sel;
        logic                 rtc_en;
    } swc_mode_t;

    function automatic logic [SWC_CNT_W-1:0] dbc_limit(input logic [SWC_SEL_W-1:0] sel);
        logic [SWC_CNT_W-1:0] lim;
        case (sel)
            3'd0:    lim = SWC_CNT_W'(0);
            3'd1:    lim = SWC_CNT_W'(3);
            3'd2:    lim = SWC_CNT_W'(32);
            3'd3:    lim = SWC_CNT_W'(512);
            3'd4:    lim = SWC_CNT_W'(4096);
            default: lim = SWC_CNT_W'(32768);
        endcase
        return lim;
    endfunction

    function automatic logic key_ok(input logic [SWC_DW-1:0] d);
        return (d[KEY_LSB +: 8] == SHUT_KEY) && d[0];
    endfunction

endpackage

// File: rtl/swc_pin_filter.sv
module swc_pin_filter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic          active,
    input  logic [CW-1:0] limit,
    output logic          hit
);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !armed || !active) begin
            run_q <= '0;
        end else if (run_q < limit) begin
            run_q <= run_q + CW'(1);
        end
    end

    assign hit = armed && active && (run_q >= limit);

endmodule

// File: rtl/swc_regfile.sv
module swc_regfile
    import swc_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ok,
    input  logic                 rd_ok,
    input  swc_reg_e             idx,
    input  logic [SWC_DW-1:0]    wdata,
    input  logic [SWC_DW-1:0]    stat_set,
    output logic [SWC_DW-1:0]    rdata,
    output swc_mode_t            mode_o,
    output logic [NPINS-1:0]     pin_en_o,
    output logic [NPINS-1:0]     pin_pol_o,
    output logic                 shut_req_o,
    output logic [SWC_DW-1:0]    stat_o
);

    swc_mode_t          mode_q;
    logic [NPINS-1:0]   en_q;
    logic [NPINS-1:0]   pol_q;
    logic [SWC_DW-1:0]  stat_q;
    logic               stat_rd;

    assign stat_rd    = rd_ok && (idx == REG_STAT);
    assign shut_req_o = wr_ok && (idx == REG_CTRL) && key_ok(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ok && idx == REG_MODE) begin
                mode_q.sel    <= wdata[SEL_LSB +: SWC_SEL_W];
                mode_q.rtc_en <= wdata[RTC_EN_BIT];
            end
            if (wr_ok && idx == REG_WCFG) begin
                en_q  <= wdata[NPINS-1:0];
                pol_q <= wdata[POL_LSB +: NPINS];
            end
            stat_q <= (stat_rd ? '0 : stat_q) | stat_set;
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            REG_MODE: begin
                rdata[SEL_LSB +: SWC_SEL_W] = mode_q.sel;
                rdata[RTC_EN_BIT]           = mode_q.rtc_en;
            end
            REG_STAT: rdata = stat_q;
            REG_WCFG: begin
                for (int i = 0; i < int'(NPINS); i++) begin
                    rdata[i]           = en_q[i];
                    rdata[POL_LSB + i] = pol_q[i];
                end
            end
            default: rdata = '0;
        endcase
    end

    assign mode_o    = mode_q;
    assign pin_en_o  = en_q;
    assign pin_pol_o = pol_q;
    assign stat_o    = stat_q;

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  wake_pin,
    input  logic              rtc_alarm,
    output logic              pwr_en
);

    localparam int unsigned CW = SWC_CNT_W;

    pwr_state_e         state_q;
    logic               aligned;
    logic               wr_ok;
    logic               rd_ok;
    swc_reg_e           idx;
    logic [31:0]        reg_rdata;
    swc_mode_t          mode;
    logic [NPINS-1:0]   pin_en;
    logic [NPINS-1:0]   pin_pol;
    logic               shut_req;
    logic [31:0]        stat_w;
    logic [31:0]        stat_set;
    logic [NPINS-1:0]   pin_act;
    logic [NPINS-1:0]   pin_hit;
    logic [CW-1:0]      limit;
    logic               armed;
    logic               rtc_hit;
    logic               wake_any;
    logic               rtc_en_w;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;
    assign rd_ok   = bus_rd && aligned;
    assign idx     = swc_reg_e'(bus_addr[3:2]);

    swc_regfile #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .idx        (idx),
        .wdata      (bus_wdata),
        .stat_set   (stat_set),
        .rdata      (reg_rdata),
        .mode_o     (mode),
        .pin_en_o   (pin_en),
        .pin_pol_o  (pin_pol),
        .shut_req_o (shut_req),
        .stat_o     (stat_w)
    );

    assign bus_rdata = aligned ? reg_rdata : '0;
    assign armed     = (state_q == PWR_OFF);
    assign limit     = dbc_limit(mode.sel);
    assign rtc_en_w  = mode.rtc_en;

    for (genvar i = 0; i < int'(NPINS); i++) begin : g_pin
        assign pin_act[i] = pin_en[i] && (wake_pin[i] == pin_pol[i]);
        swc_pin_filter #(.CW(CW)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .armed  (armed),
            .active (pin_act[i]),
            .limit  (limit),
            .hit    (pin_hit[i])
        );
    end

    assign rtc_hit  = armed && rtc_en_w && rtc_alarm;
    assign wake_any = rtc_hit || (|pin_hit);

    always_comb begin
        stat_set = '0;
        stat_set[RTC_STAT_BIT] = rtc_hit;
        stat_set[PIN_STAT_LSB +: NPINS] = pin_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_ON;
        end else begin
            case (state_q)
                PWR_ON:  if (shut_req) state_q <= PWR_OFF;
                PWR_OFF: if (wake_any) state_q <= PWR_ON;
                default: state_q <= PWR_ON;
            endcase
        end
    end

    assign pwr_en = (state_q == PWR_ON);

endmodule

// File: rtl/swc_checks.sv
module swc_checks (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        rtc_alarm,
    input logic        rtc_en,
    input logic        wake_any,
    input logic [31:0] stat,
    input logic        pwr_en
);

    logic ctrl_wr;
    logic good_key;
    assign ctrl_wr  = bus_wr && (bus_addr == 4'h0);
    assign good_key = (bus_wdata[31:24] == 8'hA5) && bus_wdata[0];

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pwr_en && stat == 32'h0));

    p_key_shutdown_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && ctrl_wr && good_key) |=> !pwr_en);

    p_bad_key_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && ctrl_wr && !good_key) |=> pwr_en);

    p_alarm_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && rtc_en && rtc_alarm) |=> (pwr_en && stat[5]));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 4'h8 && !wake_any) |=> (stat == 32'h0));

    p_no_cause_when_on_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_en |=> ((stat & ~$past(stat)) == 32'h0));

endmodule

bind sleep_wake_ctrl swc_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rtc_alarm (rtc_alarm),
    .rtc_en    (rtc_en_w),
    .wake_any  (wake_any),
    .stat      (stat_w),
    .pwr_en    (pwr_en)
);

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] wake_pin = 16'h0008;
    logic        rtc_alarm = 1'b0;
    logic        pwr_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    sleep_wake_ctrl i_sleep_wake_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_pin  (wake_pin),
        .rtc_alarm (rtc_alarm),
        .pwr_en    (pwr_en)
    );

    // ---------------- behavioural reference ----------------
    int          m_off = 0;
    int          m_cnt [16];
    logic [31:0] m_stat = 0;
    logic [2:0]  m_sel = 0;
    logic        m_rtc = 0;
    logic [31:0] m_cfg = 0;

    function automatic int lim_of(input logic [2:0] s);
        case (s)
            3'd0: return 0;
            3'd1: return 3;
            3'd2: return 32;
            3'd3: return 512;
            3'd4: return 4096;
            default: return 32768;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h4: return {5'b0, m_sel, 6'b0, m_rtc, 17'b0};
            4'h8: return m_stat;
            4'hC: return m_cfg;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] set;
        int          lim;
        int          nxt_off;
        if (rst) begin
            m_off = 0; m_stat = 0; m_sel = 0; m_rtc = 0; m_cfg = 0;
            for (int i = 0; i < 16; i++) m_cnt[i] = 0;
        end else begin
            set = 0;
            lim = lim_of(m_sel);
            nxt_off = m_off;
            if (m_off != 0) begin
                for (int i = 0; i < 16; i++) begin
                    if (m_cfg[i] && (wake_pin[i] == m_cfg[16+i])) begin
                        if (m_cnt[i] >= lim) set[16+i] = 1'b1;
                        else m_cnt[i] = m_cnt[i] + 1;
                    end else begin
                        m_cnt[i] = 0;
                    end
                end
                if (m_rtc && rtc_alarm) set[5] = 1'b1;
                if (set != 0) nxt_off = 0;
            end else begin
                for (int i = 0; i < 16; i++) m_cnt[i] = 0;
            end
            if (bus_rd && bus_addr == 4'h8) m_stat = 0;
            m_stat = m_stat | set;
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: if (m_off == 0 && bus_wdata[31:24] == 8'hA5 && bus_wdata[0]) nxt_off = 1;
                    4'h4: begin m_sel = bus_wdata[26:24]; m_rtc = bus_wdata[17]; end
                    4'hC: m_cfg = bus_wdata;
                    default: ;
                endcase
            end
            m_off = nxt_off;
        end
    end

    always @(negedge clk) begin
        #2;
        total++;
        if (pwr_en !== (m_off == 0)) begin
            bad++;
            $display("FAIL R2/R5 pwr_en vs model: got %0b expected %0b at %0t", pwr_en, (m_off == 0), $time);
        end
        if (bus_rd) begin
            total++;
            if (bus_rdata !== m_read(bus_addr)) begin
                bad++;
                $display("FAIL R8/R11 read 0x%0h vs model: got %08h expected %08h", bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // called at a falling edge with power off; pin idx held at level lv
    task automatic hold_pin(input int idx, input logic lv, input int lim, input string tag);
        wake_pin[idx] = lv;
        idle(lim);
        chk({tag, " still off before count ends"}, {31'b0, pwr_en}, 32'h0);
        idle(1);
        chk({tag, " power back after count"}, {31'b0, pwr_en}, 32'h1);
    endtask

    localparam logic [31:0] SHUT = 32'hA500_0001;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk("R1 pwr_en after reset", {31'b0, pwr_en}, 32'h1);
        rd(4'h8, d); chk("R1 status after reset", d, 32'h0);
        rd(4'h4, d); chk("R1 mode after reset", d, 32'h0);
        rd(4'hC, d); chk("R1 config after reset", d, 32'h0);

        // pin0 active-high, pin3 active-low
        wr(4'hC, 32'h0001_0009);
        rd(4'hC, d); chk("R11 config readback", d, 32'h0001_0009);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); chk("R11 mode readback masked", d, 32'h0702_0000);
        wr(4'h4, 32'h0100_0000);

        // activity while powered
        wake_pin[0] = 1'b1; rtc_alarm = 1'b1;
        idle(10);
        wake_pin[0] = 1'b0; rtc_alarm = 1'b0;
        rd(4'h8, d); chk("R10 no cause while powered", d, 32'h0);

        wr(4'h0, 32'h5A00_0001); chk("R3 wrong key", {31'b0, pwr_en}, 32'h1);
        wr(4'h0, 32'hA500_0000); chk("R3 bit0 clear", {31'b0, pwr_en}, 32'h1);
        wr(4'h0, 32'hA400_0001); chk("R3 near key", {31'b0, pwr_en}, 32'h1);
        wr(4'h0, SHUT);          chk("R2 shutdown", {31'b0, pwr_en}, 32'h0);

        // disabled pin 5 toggles, enabled pins at inactive level
        for (int k = 0; k < 6; k++) begin
            wake_pin[5] = ~wake_pin[5];
            idle(2);
        end
        chk("R4 disabled/inactive pins", {31'b0, pwr_en}, 32'h0);

        // glitch restart, L=3
        wake_pin[0] = 1'b1; idle(3);
        wake_pin[0] = 1'b0; idle(1);
        chk("R6 glitch keeps power off", {31'b0, pwr_en}, 32'h0);
        hold_pin(0, 1'b1, 3, "R6 restarted count");
        wake_pin[0] = 1'b0;
        rd(4'h8, d); chk("R8 pin0 cause", d, 32'h0001_0000);
        rd(4'h8, d); chk("R9 cleared by read", d, 32'h0);

        // active-low pin3, L=32
        wr(4'h4, 32'h0200_0000);
        wr(4'h0, SHUT);
        hold_pin(3, 1'b0, 32, "R4 active-low pin3 L=32");
        wake_pin[3] = 1'b1;
        rd(4'h8, d); chk("R8 pin3 cause", d, 32'h0008_0000);

        // alarm enabled
        wr(4'h4, 32'h0002_0000);
        wr(4'h0, SHUT);
        rtc_alarm = 1'b1; idle(1); rtc_alarm = 1'b0;
        chk("R7 alarm wake", {31'b0, pwr_en}, 32'h1);
        rd(4'h8, d); chk("R7 alarm cause", d, 32'h0000_0020);

        // alarm disabled, then pin0 with L=0
        wr(4'h4, 32'h0000_0000);
        wr(4'h0, SHUT);
        rtc_alarm = 1'b1; idle(3); rtc_alarm = 1'b0;
        chk("R7 alarm ignored when disabled", {31'b0, pwr_en}, 32'h0);
        hold_pin(0, 1'b1, 0, "R5 sel0 immediate");
        wake_pin[0] = 1'b0;
        rd(4'h8, d); chk("R7 no alarm bit", d, 32'h0001_0000);

        // simultaneous causes
        wr(4'h4, 32'h0002_0000);
        wr(4'h0, SHUT);
        wake_pin[0] = 1'b1; rtc_alarm = 1'b1; idle(1);
        wake_pin[0] = 1'b0; rtc_alarm = 1'b0;
        chk("R8 joint wake power", {31'b0, pwr_en}, 32'h1);
        rd(4'h8, d); chk("R8 both causes", d, 32'h0001_0020);

        // remaining debounce table entries
        wr(4'h4, 32'h0300_0000); wr(4'h0, SHUT);
        hold_pin(0, 1'b1, 512, "R5 sel3");
        wake_pin[0] = 1'b0;
        wr(4'h4, 32'h0400_0000); wr(4'h0, SHUT);
        hold_pin(0, 1'b1, 4096, "R5 sel4");
        wake_pin[0] = 1'b0;
        wr(4'h4, 32'h0500_0000); wr(4'h0, SHUT);
        hold_pin(0, 1'b1, 32768, "R5 sel5");
        wake_pin[0] = 1'b0;
        wr(4'h4, 32'h0700_0000); wr(4'h0, SHUT);
        hold_pin(0, 1'b1, 32768, "R5 sel7");
        wake_pin[0] = 1'b0;
        rd(4'h8, d);

        // everything disabled
        wr(4'h4, 32'h0); wr(4'hC, 32'h0);
        wr(4'h0, SHUT);
        wake_pin = 16'hFFFF; idle(5);
        wake_pin = 16'h0000; idle(5);
        rtc_alarm = 1'b1; idle(5); rtc_alarm = 1'b0;
        chk("R12 no wake source", {31'b0, pwr_en}, 32'h0);
        rd(4'h8, d); chk("R12 status empty", d, 32'h0);

        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        chk("R1 reset restores power", {31'b0, pwr_en}, 32'h1);
        rd(4'h4, d); chk("R1 mode cleared", d, 32'h0);

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule